// File: doc/BRIEF.md
# Windowed Mirrored Subsampling Address Sequencer

This block walks the readout addresses of a Bayer-pattern pixel array that spans columns 0 to 687 and rows 0 to 507. Software sets a rectangular window (start row, start column, row depth, column width), a mirror bit per direction and a subsampling rate per direction. On every accepted data-clock enable the block emits one column/row address pair, tagged with start-of-line, end-of-line and end-of-frame flags. Frames run back to back.

Both directions work on two-pixel Bayer pairs. The column start is forced even, so every line opens on the red/green column pair. Sizes are rounded down to whole pairs. At rate 1/N one pair is read and the next N-1 pairs are skipped. A window that would cross the array edge is cut at the last valid address. Settings are captured in a single frame-start cycle that follows reset and follows every end-of-frame output. A change made mid-frame therefore only affects the next frame.

Top module: `addr_seq_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_vld` is low.
- R2: `out_vld` rises only in the cycle after a rising clock edge at which `pix_en` was high. It carries one address per accepted enable. An enable that meets a frame-start cycle is ignored.
- R3: The column start has bit 0 cleared. A start above `NUM_COLS-2` is replaced by `NUM_COLS-2`. Inside a line, bit 0 of consecutive output columns alternates.
- R4: Column width is halved and rounded down to a pair count. A count of zero becomes one pair. The pair count is reduced so that no column exceeds `NUM_COLS-1`.
- R5: Row start above `NUM_ROWS-2` is replaced by `NUM_ROWS-2`. Row depth is halved and rounded down to a pair count, with a minimum of one pair. The pair count is reduced so that no row exceeds `NUM_ROWS-1`.
- R6: With both mirror bits low, the frame is row-major. Rows ascend from the window top, and inside each line the columns ascend from the window start. The row address is constant within a line.
- R7: With `cfg_mirror_h` high, each line presents exactly the reverse of the unmirrored column sequence.
- R8: With `cfg_mirror_v` high, the frame presents exactly the reverse of the unmirrored row sequence.
- R9: `cfg_rate_col` codes 0, 1, 2 and 3 select N = 1, 2, 3 and 4. Only column pairs whose index from the window start is a multiple of N are read. Both columns of each such pair are output.
- R10: `cfg_rate_row` uses the same coding and applies to row pairs, independently of the column rate.
- R11: `out_sol` marks the first address of a line and `out_eol` marks the last. `out_eof` marks the last address of the frame and always comes with `out_eol`. All flags are low whenever `out_vld` is low.
- R12: Configuration inputs are sampled only in the frame-start cycle. A change made during a frame leaves that frame intact and takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Data-clock enable; one address per accepted enable |
| cfg_row_start | input | 9 | Window top row |
| cfg_col_start | input | 10 | Window left column (bit 0 ignored) |
| cfg_row_depth | input | 9 | Window height in rows |
| cfg_col_width | input | 10 | Window width in columns |
| cfg_mirror_h | input | 1 | Reverse column order |
| cfg_mirror_v | input | 1 | Reverse row order |
| cfg_rate_row | input | 2 | Row subsampling code (0..3 for 1, 1/2, 1/3, 1/4) |
| cfg_rate_col | input | 2 | Column subsampling code (0..3 for 1, 1/2, 1/3, 1/4) |
| out_vld | output | 1 | Output address valid |
| out_col | output | 10 | Column address |
| out_row | output | 9 | Row address |
| out_sol | output | 1 | First address of a line |
| out_eol | output | 1 | Last address of a line |
| out_eof | output | 1 | Last address of the frame |

## Verification
The bench builds the block with its default geometry of 688 by 508, so the edge-clipping constants are the real ones. Windows can be placed against the right and bottom borders, and start registers can be loaded beyond them, which exercises the clamping logic on its true limits. Frames are kept small so that each mirror and rate combination, including the 1/3 rate with its non-power-of-two grid, is covered in full. A new setting is written mid-frame every time, which tests frame-start sampling at each frame boundary.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

    // Default array geometry
    localparam int ARRAY_COLS = 688;
    localparam int ARRAY_ROWS = 508;

    // Subsampling selector: stride in Bayer pairs is code + 1
    typedef enum logic [1:0] {
        RATE_FULL    = 2'd0,
        RATE_HALF    = 2'd1,
        RATE_THIRD   = 2'd2,
        RATE_QUARTER = 2'd3
    } rate_e;

    // Flags that travel with each output address
    typedef struct packed {
        logic sol;
        logic eol;
        logic eof;
    } line_flags_t;

    // Pair stride for a rate
    function automatic logic [2:0] rate_stride(rate_e r);
        return {1'b0, r} + 3'd1;
    endfunction

    // Largest multiple of the stride that does not exceed v
    function automatic logic [15:0] grid_floor(logic [15:0] v, rate_e r);
        logic [15:0] res;
        case (r)
            RATE_FULL:    res = v;
            RATE_HALF:    res = {v[15:1], 1'b0};
            RATE_THIRD:   res = v - (v % 16'd3);
            default:      res = {v[15:2], 2'b00};
        endcase
        return res;
    endfunction

endpackage

// File: rtl/addr_seq_axis.sv
module addr_seq_axis
    import addr_seq_pkg::*;
#(
    parameter int NUM        = 688,
    parameter bit FORCE_EVEN = 1'b1,
    localparam int W         = $clog2(NUM),
    localparam int LIMIT     = NUM - 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] start,
    input  logic [W-1:0] extent,
    input  logic         mirror,
    input  rate_e        rate,
    output logic [W-1:0] addr,
    output logic         first,
    output logic         last
);

    logic [W-1:0] start_al;
    logic [W-1:0] base_n;
    logic [W-1:0] req_n;
    logic [W:0]   span_n;
    logic [W-1:0] avail_n;
    logic [W-1:0] pairs_n;
    logic [W-1:0] plast_n;

    // Variant: column axis aligns to the Bayer pair, row axis does not
    generate
        if (FORCE_EVEN) begin : g_even
            assign start_al = {start[W-1:1], 1'b0};
        end else begin : g_any
            assign start_al = start;
        end
    endgenerate

    always_comb begin
        base_n  = (start_al > W'(LIMIT)) ? W'(LIMIT) : start_al;
        req_n   = extent >> 1;
        if (req_n == '0) begin
            req_n = W'(1);
        end
        span_n  = (W+1)'(NUM) - {1'b0, base_n};
        avail_n = span_n[W:1];
        pairs_n = (req_n < avail_n) ? req_n : avail_n;
        plast_n = W'(grid_floor(16'(pairs_n - W'(1)), rate));
    end

    // Frame-held window state
    logic [W-1:0] base_q;
    logic [W-1:0] plast_q;
    logic         mir_q;
    logic [2:0]   stride_q;
    logic [W-1:0] pidx_q;
    logic         bit_q;

    logic [W-1:0] sp;
    logic         sb;
    logic [W-1:0] ep;
    logic         eb;

    always_comb begin
        sp    = mir_q ? plast_q : '0;
        sb    = mir_q;
        ep    = mir_q ? '0 : plast_q;
        eb    = ~mir_q;
        first = (pidx_q == sp) && (bit_q == sb);
        last  = (pidx_q == ep) && (bit_q == eb);
        addr  = base_q + {pidx_q[W-2:0], bit_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            plast_q  <= '0;
            mir_q    <= 1'b0;
            stride_q <= 3'd1;
            pidx_q   <= '0;
            bit_q    <= 1'b0;
        end else if (load) begin
            base_q   <= base_n;
            plast_q  <= plast_n;
            mir_q    <= mirror;
            stride_q <= rate_stride(rate);
            pidx_q   <= mirror ? plast_n : '0;
            bit_q    <= mirror;
        end else if (step) begin
            if (last) begin
                pidx_q <= sp;
                bit_q  <= sb;
            end else if (!mir_q) begin
                bit_q <= ~bit_q;
                if (bit_q) begin
                    pidx_q <= pidx_q + W'(stride_q);
                end
            end else begin
                bit_q <= ~bit_q;
                if (!bit_q) begin
                    pidx_q <= pidx_q - W'(stride_q);
                end
            end
        end
    end

endmodule

// File: rtl/addr_seq_frame_ctrl.sv
module addr_seq_frame_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    input  logic col_last,
    input  logic row_last,
    output logic load,
    output logic fire,
    output logic row_step,
    output logic frame_end
);

    logic load_pend_q;

    always_comb begin
        load      = load_pend_q;
        fire      = pix_en & ~load_pend_q;
        row_step  = fire & col_last;
        frame_end = fire & col_last & row_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_pend_q <= 1'b1;
        end else if (load_pend_q) begin
            load_pend_q <= 1'b0;
        end else if (frame_end) begin
            load_pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/addr_seq_gen.sv
module addr_seq_gen
    import addr_seq_pkg::*;
#(
    parameter int NUM_COLS = ARRAY_COLS,
    parameter int NUM_ROWS = ARRAY_ROWS,
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic [ROW_W-1:0] cfg_row_start,
    input  logic [COL_W-1:0] cfg_col_start,
    input  logic [ROW_W-1:0] cfg_row_depth,
    input  logic [COL_W-1:0] cfg_col_width,
    input  logic             cfg_mirror_h,
    input  logic             cfg_mirror_v,
    input  logic [1:0]       cfg_rate_row,
    input  logic [1:0]       cfg_rate_col,
    output logic             out_vld,
    output logic [COL_W-1:0] out_col,
    output logic [ROW_W-1:0] out_row,
    output logic             out_sol,
    output logic             out_eol,
    output logic             out_eof
);

    logic             load;
    logic             fire;
    logic             row_step;
    logic             frame_end;
    logic [COL_W-1:0] col_addr;
    logic [ROW_W-1:0] row_addr;
    logic             col_first;
    logic             col_last;
    logic             row_first;
    logic             row_last;

    addr_seq_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .col_last  (col_last),
        .row_last  (row_last),
        .load      (load),
        .fire      (fire),
        .row_step  (row_step),
        .frame_end (frame_end)
    );

    addr_seq_axis #(.NUM(NUM_COLS), .FORCE_EVEN(1'b1)) u_col_axis (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (fire),
        .start  (cfg_col_start),
        .extent (cfg_col_width),
        .mirror (cfg_mirror_h),
        .rate   (rate_e'(cfg_rate_col)),
        .addr   (col_addr),
        .first  (col_first),
        .last   (col_last)
    );

    addr_seq_axis #(.NUM(NUM_ROWS), .FORCE_EVEN(1'b0)) u_row_axis (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (row_step),
        .start  (cfg_row_start),
        .extent (cfg_row_depth),
        .mirror (cfg_mirror_v),
        .rate   (rate_e'(cfg_rate_row)),
        .addr   (row_addr),
        .first  (row_first),
        .last   (row_last)
    );

    // Output register stage
    line_flags_t      flags_q;
    logic             vld_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            flags_q <= '0;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            vld_q <= fire;
            if (fire) begin
                col_q       <= col_addr;
                row_q       <= row_addr;
                flags_q.sol <= col_first;
                flags_q.eol <= col_last;
                flags_q.eof <= frame_end;
            end else begin
                flags_q <= '0;
            end
        end
    end

    assign out_vld = vld_q;
    assign out_col = col_q;
    assign out_row = row_q;
    assign out_sol = flags_q.sol;
    assign out_eol = flags_q.eol;
    assign out_eof = flags_q.eof;

    // Row-first flag is part of the axis interface; frame start is tracked by the controller
    logic unused_ok;
    assign unused_ok = row_first;

endmodule

// File: rtl/addr_seq_checker.sv
module addr_seq_checker #(
    parameter int NUM_COLS = 688,
    parameter int NUM_ROWS = 508,
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic             out_vld,
    input logic [COL_W-1:0] out_col,
    input logic [ROW_W-1:0] out_row,
    input logic             out_sol,
    input logic             out_eol,
    input logic             out_eof
);

    logic [ROW_W-1:0] prev_row;
    logic             prev_par;
    logic             want_sol;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_row <= '0;
            prev_par <= 1'b0;
            want_sol <= 1'b1;
        end else if (out_vld) begin
            prev_row <= out_row;
            prev_par <= out_col[0];
            want_sol <= out_eol;
        end
    end

    p_vld_after_en_r2: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(pix_en));

    p_flags_need_vld_r11: assert property (@(posedge clk) disable iff (rst)
        (out_sol | out_eol | out_eof) |-> out_vld);

    p_eof_has_eol_r11: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_eof) |-> out_eol);

    p_sol_after_eol_r11: assert property (@(posedge clk) disable iff (rst)
        (out_vld && want_sol) |-> out_sol);

    p_row_held_in_line_r6: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_sol) |-> (out_row == prev_row));

    p_col_parity_alt_r3: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_sol) |-> (out_col[0] != prev_par));

    p_col_in_array_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_col <= COL_W'(NUM_COLS - 1)));

    p_row_in_array_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_row <= ROW_W'(NUM_ROWS - 1)));

endmodule

bind addr_seq_gen addr_seq_checker #(
    .NUM_COLS(NUM_COLS),
    .NUM_ROWS(NUM_ROWS)
) u_addr_seq_checker (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .out_vld (out_vld),
    .out_col (out_col),
    .out_row (out_row),
    .out_sol (out_sol),
    .out_eol (out_eol),
    .out_eof (out_eof)
);

// File: tb/addr_seq_gen_tb_top.sv
`timescale 1ns/100ps
module addr_seq_gen_tb_top;

    localparam int NC = 688;
    localparam int NR = 508;
    localparam int CW = $clog2(NC);
    localparam int RW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_en = 1'b0;
    logic [RW-1:0] cfg_row_start = '0;
    logic [CW-1:0] cfg_col_start = '0;
    logic [RW-1:0] cfg_row_depth = '0;
    logic [CW-1:0] cfg_col_width = '0;
    logic          cfg_mirror_h = 1'b0;
    logic          cfg_mirror_v = 1'b0;
    logic [1:0]    cfg_rate_row = '0;
    logic [1:0]    cfg_rate_col = '0;
    logic          out_vld;
    logic [CW-1:0] out_col;
    logic [RW-1:0] out_row;
    logic          out_sol;
    logic          out_eol;
    logic          out_eof;

    always #2.5 clk = ~clk;

    addr_seq_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .pix_en        (pix_en),
        .cfg_row_start (cfg_row_start),
        .cfg_col_start (cfg_col_start),
        .cfg_row_depth (cfg_row_depth),
        .cfg_col_width (cfg_col_width),
        .cfg_mirror_h  (cfg_mirror_h),
        .cfg_mirror_v  (cfg_mirror_v),
        .cfg_rate_row  (cfg_rate_row),
        .cfg_rate_col  (cfg_rate_col),
        .out_vld       (out_vld),
        .out_col       (out_col),
        .out_row       (out_row),
        .out_sol       (out_sol),
        .out_eol       (out_eol),
        .out_eof       (out_eof)
    );

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic          sol;
        logic          eol;
        logic          eof;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    bit    checking = 1'b1;
    bit    finished = 1'b0;
    logic  en_at_edge = 1'b0;

    always @(posedge clk) en_at_edge <= pix_en;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: program a window and queue the frame it should produce
    task automatic push_frame(input int rs, input int d, input int cs, input int w,
                              input bit mh, input bit mv, input int rr, input int rc,
                              input string tag);
        int cols[$];
        int rows[$];
        int cols_o[$];
        int rows_o[$];
        int cse, p, rse, q;
        cse = cs & ~1;
        if (cse > NC - 2) cse = NC - 2;
        p = w / 2;
        if (p < 1) p = 1;
        if (p > (NC - cse) / 2) p = (NC - cse) / 2;
        for (int k = 0; k < p; k += rc + 1) begin
            cols.push_back(cse + 2 * k);
            cols.push_back(cse + 2 * k + 1);
        end
        rse = rs;
        if (rse > NR - 2) rse = NR - 2;
        q = d / 2;
        if (q < 1) q = 1;
        if (q > (NR - rse) / 2) q = (NR - rse) / 2;
        for (int k = 0; k < q; k += rr + 1) begin
            rows.push_back(rse + 2 * k);
            rows.push_back(rse + 2 * k + 1);
        end
        for (int i = 0; i < cols.size(); i++)
            cols_o.push_back(mh ? cols[cols.size() - 1 - i] : cols[i]);
        for (int i = 0; i < rows.size(); i++)
            rows_o.push_back(mv ? rows[rows.size() - 1 - i] : rows[i]);
        cfg_row_start = RW'(rs);
        cfg_row_depth = RW'(d);
        cfg_col_start = CW'(cs);
        cfg_col_width = CW'(w);
        cfg_mirror_h  = mh;
        cfg_mirror_v  = mv;
        cfg_rate_row  = 2'(rr);
        cfg_rate_col  = 2'(rc);
        for (int r = 0; r < rows_o.size(); r++) begin
            for (int c = 0; c < cols_o.size(); c++) begin
                item_t it;
                it.col = CW'(cols_o[c]);
                it.row = RW'(rows_o[r]);
                it.sol = (c == 0);
                it.eol = (c == cols_o.size() - 1);
                it.eof = it.eol && (r == rows_o.size() - 1);
                exp_q.push_back(it);
                tag_q.push_back(tag);
            end
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (checking && !rst && out_vld) begin
            item_t act;
            act = {out_col, out_row, out_sol, out_eol, out_eof};
            check(en_at_edge == 1'b1, "R2", "output without enable", 0, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R12", "unexpected output", longint'(act), 0);
            end else begin
                item_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, "item {col,row,sol,eol,eof}", longint'(act), longint'(e));
            end
        end
    end

    // Enable pattern: about three enables in four cycles
    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pix_en = lfsr[0] | lfsr[1];
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R2", "watchdog expired", exp_q.size(), 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic next_frame(input int rs, input int d, input int cs, input int w,
                              input bit mh, input bit mv, input int rr, input int rc,
                              input string tag);
        int n;
        @(negedge clk);
        n = exp_q.size();
        push_frame(rs, d, cs, w, mh, mv, rr, rc, tag);
        n = exp_q.size() - n;
        // wait until the first item of this frame has been seen
        wait (exp_q.size() < n);
    endtask

    initial begin
        int n0;
        // R6: plain window, cols 20..25, rows 10..13
        push_frame(10, 4, 20, 6, 1'b0, 1'b0, 0, 0, "R6");
        n0 = exp_q.size();
        repeat (4) @(negedge clk);
        check(out_vld == 1'b0, "R1", "out_vld in reset", out_vld, 0);
        check(out_sol == 1'b0, "R11", "out_sol in reset", out_sol, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0, "R1", "out_vld in frame-start cycle", out_vld, 0);
        wait (exp_q.size() < n0);
        // R3: odd start 33 -> 32, width 5 -> 2 pairs; row depth 3 -> 1 pair (R5)
        next_frame(3, 3, 33, 5, 1'b0, 1'b0, 0, 0, "R3");
        // R7 + R9: mirrored columns at rate 1/3
        next_frame(0, 2, 100, 8, 1'b1, 1'b0, 0, 2, "R7");
        // R8 + R10: mirrored rows at rate 1/2
        next_frame(40, 12, 0, 4, 1'b0, 1'b1, 1, 0, "R8");
        // R4 + R5: window clipped at right and bottom edges
        next_frame(500, 30, 680, 40, 1'b0, 1'b0, 1, 3, "R4");
        // R5 + R3: starts beyond the array, zero sizes, both mirrors
        next_frame(511, 0, 1000, 0, 1'b1, 1'b1, 0, 0, "R5");
        // R9 + R10 + R12: column rate 1/2, row rate 1/4, both mirrors
        next_frame(200, 16, 50, 10, 1'b1, 1'b1, 3, 1, "R9");
        wait (exp_q.size() == 0);
        @(posedge clk);
        checking = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule